// File: doc/BRIEF.md
# IO Interrupt Redirection Controller

This block turns a bank of external interrupt pins into interrupt messages. Each pin has its own redirection entry. The entry holds the vector to deliver, a 3-bit delivery-mode code, a 16-bit destination, the pin's polarity, its trigger mode and a mask bit. When a pin becomes eligible, the block builds a message of vector, delivery mode and destination. It presents that message on a valid/ready output. When several pins are eligible in the same cycle, the lowest-numbered pin is served first.

Software reaches the block through a small indirect register port:

- **Offset 0x00** is an index register.
- **Offset 0x10** is a data window onto the internal register that the index selects.
- **Offset 0x40** is a direct end-of-interrupt port.

The internal registers are a read-only version word and, for each entry, a low word and a high word.

Edge sources are delivered once for each activation. An activation that happens while the entry is masked is thrown away. Level sources are delivered once, then stay locked by a remote-pending flag. A write to the end-of-interrupt port carrying their vector unlocks them again. Several pins may share one vector. The pin inputs are expected to be synchronised already.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, no message is valid, the index register reads 0, and every entry reads low word 0x0001_0000 (only the mask bit set) and high word 0.
- R2: Bus offset 0x00 reads and writes the 8-bit index in bits 7:0. Offset 0x10 reads and writes the register that the index selects: entry n's low word at index 0x10+2n, its high word at 0x11+2n. Any other index, and any offset other than 0x00 and 0x10, reads 0, and writes to them change no register.
- R3: Index 0x01 reads the version word: bits 7:0 hold VERSION_CODE, bits 23:16 hold NUM_PINS-1, and all other bits are 0. Writes to it have no effect.
- R4: Low word fields: vector in bits 7:0, delivery mode in bits 10:8, polarity in bit 13 (1 = active low), remote-pending in bit 14 (read-only), trigger in bit 15 (1 = level), mask in bit 16. All other bits read 0.
- R5: The high word holds the destination in bits 31:16, and its bits 15:0 read 0. A message carries the entry's vector, delivery mode and destination.
- R6: An edge entry that is unmasked produces exactly one message each time its input becomes active. An input that is held active produces no further messages.
- R7: An edge activation that arrives while the entry is masked is dropped. Unmasking the entry later does not produce a message.
- R8: A level entry that is unmasked, active and not remote-pending produces one message. Remote-pending is set when that message is taken into the output, and while it is set the entry produces no more messages.
- R9: A write to offset 0x40 with a vector in bits 7:0 clears remote-pending in every entry programmed with that vector, and a still-active input then produces a new message. A write with a different vector leaves remote-pending set.
- R10: While msg_valid is high and msg_ready is low, the message fields hold steady. A new message is loaded only into an empty or accepted output slot.
- R11: When several entries are eligible in the same cycle, the lowest-numbered one is delivered first, and the others follow in later cycles.
- R12: With polarity set to active low, a low input level counts as asserted and a high level counts as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_PINS | Synchronised interrupt pins |
| bus_addr | input | 7 | Register port offset |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Register write strobe |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message taken by the receiver |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery-mode code |
| msg_dest | output | 16 | Message destination |

## Verification
The bench builds the block with NUM_PINS = 5 and VERSION_CODE = 0x3C. An odd pin count puts the first unused index (0x1A) right after the last high word, so the decoder boundary is exercised. A non-trivial version code makes both version fields distinguishable from zero. Five pins leave room for two level pins sharing one vector and for two edge pins racing in the arbiter. Meanwhile, the other entries stay masked and show that they stay quiet.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   // Bus offsets (7-bit register port)
   localparam logic [6:0] OFS_INDEX  = 7'h00;
   localparam logic [6:0] OFS_WINDOW = 7'h10;
   localparam logic [6:0] OFS_EOI    = 7'h40;

   // Internal indices
   localparam logic [7:0] IDX_VERSION    = 8'h01;
   localparam logic [7:0] IDX_ENTRY_BASE = 8'h10;
   localparam int         MAX_PINS       = 120;

   // Low word bit positions
   localparam int VEC_LSB  = 0;
   localparam int DM_LSB   = 8;
   localparam int POL_BIT  = 13;
   localparam int RP_BIT   = 14;
   localparam int TRIG_BIT = 15;
   localparam int MASK_BIT = 16;
   // High word
   localparam int DEST_LSB = 16;

   typedef struct packed {
      logic [7:0] vector;
      logic [2:0] dmode;
      logic       active_low;
      logic       level;
      logic       mask;
   } low_fields_t;

   typedef struct packed {
      logic [7:0]  vector;
      logic [2:0]  dmode;
      logic [15:0] dest;
   } redir_msg_t;

   localparam low_fields_t LOW_RESET = '{vector: 8'h00, dmode: 3'd0,
                                         active_low: 1'b0, level: 1'b0,
                                         mask: 1'b1};

   function automatic logic [31:0] low_to_word(low_fields_t f, logic rp);
      logic [31:0] w;
      w = '0;
      w[VEC_LSB +: 8] = f.vector;
      w[DM_LSB +: 3]  = f.dmode;
      w[POL_BIT]      = f.active_low;
      w[RP_BIT]       = rp;
      w[TRIG_BIT]     = f.level;
      w[MASK_BIT]     = f.mask;
      return w;
   endfunction

   function automatic low_fields_t word_to_low(logic [31:0] w);
      low_fields_t f;
      f.vector     = w[VEC_LSB +: 8];
      f.dmode      = w[DM_LSB +: 3];
      f.active_low = w[POL_BIT];
      f.level      = w[TRIG_BIT];
      f.mask       = w[MASK_BIT];
      return f;
   endfunction

endpackage

// File: rtl/irq_redir_regif.sv
module irq_redir_regif
   import irq_redir_pkg::*;
#(
   parameter int         NUM_PINS     = 8,
   parameter logic [7:0] VERSION_CODE = 8'h21
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [6:0]                   bus_addr,
   input  logic [31:0]                  bus_wdata,
   input  logic                         bus_we,
   output logic [31:0]                  bus_rdata,
   output logic [NUM_PINS-1:0]          we_low,
   output logic [NUM_PINS-1:0]          we_high,
   output low_fields_t                  wr_fields,
   output logic [15:0]                  wr_dest,
   output logic                         eoi_valid,
   output logic [7:0]                   eoi_vector,
   input  logic [NUM_PINS-1:0][31:0]    low_words,
   input  logic [NUM_PINS-1:0][31:0]    high_words
);

   localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

   logic [7:0]  index_q;
   logic [7:0]  rel;
   logic [6:0]  ent;
   logic        hi_half;
   logic        hit_entry;
   logic        win_wr;
   logic [31:0] win_rd;

   assign rel       = index_q - IDX_ENTRY_BASE;
   assign ent       = rel[7:1];
   assign hi_half   = rel[0];
   assign hit_entry = (index_q >= IDX_ENTRY_BASE) && ({25'd0, ent} < 32'(NUM_PINS));
   assign win_wr    = bus_we && (bus_addr == OFS_WINDOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         index_q <= 8'h00;
      else if (bus_we && bus_addr == OFS_INDEX)
         index_q <= bus_wdata[7:0];
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_wen
         assign we_low[gi]  = win_wr && hit_entry && !hi_half && (ent == 7'(gi));
         assign we_high[gi] = win_wr && hit_entry &&  hi_half && (ent == 7'(gi));
      end
   endgenerate

   assign wr_fields  = word_to_low(bus_wdata);
   assign wr_dest    = bus_wdata[DEST_LSB +: 16];
   assign eoi_valid  = bus_we && (bus_addr == OFS_EOI);
   assign eoi_vector = bus_wdata[7:0];

   always_comb begin
      win_rd = '0;
      if (index_q == IDX_VERSION) begin
         win_rd = VERSION_WORD;
      end else if (hit_entry) begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (ent == 7'(i))
               win_rd = hi_half ? high_words[i] : low_words[i];
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         OFS_INDEX:  bus_rdata = {24'd0, index_q};
         OFS_WINDOW: bus_rdata = win_rd;
         default:    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
   import irq_redir_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        irq_sync,
   input  logic        we_low,
   input  logic        we_high,
   input  low_fields_t wr_fields,
   input  logic [15:0] wr_dest,
   input  logic        eoi_valid,
   input  logic [7:0]  eoi_vector,
   input  logic        grant,
   output logic        req,
   output redir_msg_t  msg,
   output logic [31:0] low_word,
   output logic [31:0] high_word,
   output logic        mask_o,
   output logic        rp_o,
   output logic        level_o
);

   low_fields_t cfg_q;
   logic [15:0] dest_q;
   logic        prev_q;
   logic        pend_q;
   logic        rp_q;
   logic        active;
   logic        rise;

   assign active = irq_sync ^ cfg_q.active_low;
   assign rise   = active & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= LOW_RESET;
         dest_q <= '0;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         rp_q   <= 1'b0;
      end else begin
         if (we_low)
            cfg_q <= wr_fields;
         if (we_high)
            dest_q <= wr_dest;
         prev_q <= active;
         // edge latch: masked activations are dropped, a grant consumes it
         pend_q <= (pend_q | rise) & ~cfg_q.mask & ~cfg_q.level & ~grant;
         if (grant && cfg_q.level)
            rp_q <= 1'b1;
         else if (eoi_valid && eoi_vector == cfg_q.vector)
            rp_q <= 1'b0;
      end
   end

   assign req = ~cfg_q.mask & (cfg_q.level ? (active & ~rp_q) : (pend_q | rise));

   assign msg.vector = cfg_q.vector;
   assign msg.dmode  = cfg_q.dmode;
   assign msg.dest   = dest_q;

   assign low_word  = low_to_word(cfg_q, rp_q);
   assign high_word = {dest_q, 16'd0};
   assign mask_o    = cfg_q.mask;
   assign rp_o      = rp_q;
   assign level_o   = cfg_q.level;

endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb #(
   parameter int N = 8
)(
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   logic [N:0] below;

   assign below[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_chain
         assign below[gi+1] = below[gi] | req[gi];
         assign grant[gi]   = en & req[gi] & ~below[gi];
      end
   endgenerate

   assign any = below[N];

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
   import irq_redir_pkg::*;
#(
   parameter int         NUM_PINS     = 8,
   parameter logic [7:0] VERSION_CODE = 8'h21
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_in,
   input  logic [6:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic                bus_we,
   output logic [31:0]         bus_rdata,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [7:0]          msg_vector,
   output logic [2:0]          msg_dmode,
   output logic [15:0]         msg_dest
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
         $error("irq_redir_ctrl: NUM_PINS must lie in 1..%0d", MAX_PINS);
      end
   endgenerate

   logic [NUM_PINS-1:0]       we_low, we_high;
   logic [NUM_PINS-1:0]       req_vec, grant_vec, mask_vec, rp_vec, level_vec;
   low_fields_t               wr_fields;
   logic [15:0]               wr_dest;
   logic                      eoi_valid;
   logic [7:0]                eoi_vector;
   logic [NUM_PINS-1:0][31:0] low_words, high_words;
   redir_msg_t [NUM_PINS-1:0] entry_msg;
   redir_msg_t                win_msg, out_q;
   logic                      valid_q, slot_free, any_req;

   irq_redir_regif #(.NUM_PINS(NUM_PINS), .VERSION_CODE(VERSION_CODE)) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_we     (bus_we),
      .bus_rdata  (bus_rdata),
      .we_low     (we_low),
      .we_high    (we_high),
      .wr_fields  (wr_fields),
      .wr_dest    (wr_dest),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .low_words  (low_words),
      .high_words (high_words)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_entry
         irq_redir_entry u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq_sync   (irq_in[gi]),
            .we_low     (we_low[gi]),
            .we_high    (we_high[gi]),
            .wr_fields  (wr_fields),
            .wr_dest    (wr_dest),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .grant      (grant_vec[gi]),
            .req        (req_vec[gi]),
            .msg        (entry_msg[gi]),
            .low_word   (low_words[gi]),
            .high_word  (high_words[gi]),
            .mask_o     (mask_vec[gi]),
            .rp_o       (rp_vec[gi]),
            .level_o    (level_vec[gi])
         );
      end
   endgenerate

   assign slot_free = ~valid_q | msg_ready;

   irq_redir_arb #(.N(NUM_PINS)) u_arb (
      .en    (slot_free),
      .req   (req_vec),
      .grant (grant_vec),
      .any   (any_req)
   );

   always_comb begin
      win_msg = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (grant_vec[i])
            win_msg = win_msg | entry_msg[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         out_q   <= '0;
      end else if (slot_free) begin
         valid_q <= any_req;
         if (any_req)
            out_q <= win_msg;
      end
   end

   assign msg_valid  = valid_q;
   assign msg_vector = out_q.vector;
   assign msg_dmode  = out_q.dmode;
   assign msg_dest   = out_q.dest;

endmodule

// File: rtl/irq_redir_checker.sv
module irq_redir_checker #(
   parameter int NUM_PINS = 8
)(
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] req_vec,
   input logic [NUM_PINS-1:0] grant_vec,
   input logic [NUM_PINS-1:0] mask_vec,
   input logic [NUM_PINS-1:0] rp_vec,
   input logic [NUM_PINS-1:0] level_vec,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic [7:0]          msg_vector,
   input logic [2:0]          msg_dmode,
   input logic [15:0]         msg_dest
);

   assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                     $stable(msg_dmode) && $stable(msg_dest)));

   assert_grant_slot_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_vec) |-> (!msg_valid || msg_ready));

   assert_grant_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_vec) |=> msg_valid);

   assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));

   assert_grant_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vec & ~req_vec) == '0);

   assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec & mask_vec) == '0);

   assert_pending_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec & level_vec & rp_vec) == '0);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_lock
         assert_level_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_vec[gi] && level_vec[gi]) |=> rp_vec[gi]);
      end
   endgenerate

endmodule

bind irq_redir_ctrl irq_redir_checker #(.NUM_PINS(NUM_PINS)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_vec    (req_vec),
   .grant_vec  (grant_vec),
   .mask_vec   (mask_vec),
   .rp_vec     (rp_vec),
   .level_vec  (level_vec),
   .msg_valid  (msg_valid),
   .msg_ready  (msg_ready),
   .msg_vector (msg_vector),
   .msg_dmode  (msg_dmode),
   .msg_dest   (msg_dest)
);

// File: tb/irq_redir_ctrl_bench.sv
`timescale 1ns/1ps
module irq_redir_ctrl_bench;

   localparam int         NP = 5;
   localparam logic [7:0] VC = 8'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] irq_in = '0;
   logic [6:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_rdata;
   logic          msg_valid;
   logic          msg_ready = 1'b1;
   logic [7:0]    msg_vector;
   logic [2:0]    msg_dmode;
   logic [15:0]   msg_dest;

   int compared = 0;
   int mismatched = 0;

   irq_redir_ctrl #(.NUM_PINS(NP), .VERSION_CODE(VC)) u_irq_redir_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_dest(msg_dest)
   );

   always #2 clk = ~clk;

   // {index, write data, expected readback}
   localparam int NROWS = 9;
   localparam logic [71:0] REG_TABLE [NROWS] = '{
      {8'h10, 32'hFFFF_FFFF, 32'h0001_A7FF},   // R4 all fields, RO bit 14 kept 0
      {8'h11, 32'hFFFF_FFFF, 32'hFFFF_0000},   // R5 only destination stored
      {8'h19, 32'h1234_5678, 32'h1234_0000},   // R5 last high word
      {8'h18, 32'h0000_5AC5, 32'h0000_02C5},   // R4 reserved bits dropped
      {8'h12, 32'h0001_E0AA, 32'h0001_A0AA},   // R4 remote-pending not writable
      {8'h01, 32'hFFFF_FFFF, 32'h0004_003C},   // R3 version, write ignored
      {8'h1A, 32'hFFFF_FFFF, 32'h0000_0000},   // R2 first index past entries
      {8'h05, 32'hFFFF_FFFF, 32'h0000_0000},   // R2 unmapped index
      {8'hFF, 32'hFFFF_FFFF, 32'h0000_0000}    // R2 top index
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
      bus_wr(7'h00, {24'd0, idx});
      bus_wr(7'h10, d);
   endtask

   task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
      bus_wr(7'h00, {24'd0, idx});
      bus_rd(7'h10, d);
   endtask

   task automatic count_msgs(input int n, output int c);
      c = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (msg_valid && msg_ready) c++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      irq_in = '0; msg_ready = 1'b1; bus_we = 1'b0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #(4 * 100000);
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int c;

      // ---- reset state (R1)
      do_reset();
      chk("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
      bus_rd(7'h00, rd);  chk("R1 index", rd, 32'd0);
      reg_read(8'h10, rd); chk("R1 entry0 low", rd, 32'h0001_0000);
      reg_read(8'h18, rd); chk("R1 entry4 low", rd, 32'h0001_0000);
      reg_read(8'h19, rd); chk("R1 entry4 high", rd, 32'h0000_0000);

      // ---- register table walk (R2 R3 R4 R5)
      for (int i = 0; i < NROWS; i++) begin
         reg_write(REG_TABLE[i][71:64], REG_TABLE[i][63:32]);
         reg_read(REG_TABLE[i][71:64], rd);
         chk($sformatf("R2-table row %0d", i), rd, REG_TABLE[i][31:0]);
      end
      bus_rd(7'h00, rd);  chk("R2 index readback", rd, 32'h0000_00FF);
      bus_rd(7'h20, rd);  chk("R2 unmapped offset", rd, 32'd0);

      // ---- edge delivery (R6, R5 fields)
      do_reset();
      reg_write(8'h13, 32'h1234_0000);
      reg_write(8'h12, 32'h0000_0141);      // edge, high, dmode 1, vec 0x41, unmasked
      @(negedge clk); irq_in[1] = 1'b1;
      @(negedge clk);
      chk("R6 valid", {31'd0, msg_valid}, 32'd1);
      chk("R5 vector", {24'd0, msg_vector}, 32'h41);
      chk("R5 dmode", {29'd0, msg_dmode}, 32'd1);
      chk("R5 dest", {16'd0, msg_dest}, 32'h1234);
      count_msgs(6, c);
      chk("R6 held input no repeat", c, 0);

      // ---- masked edge dropped (R7)
      do_reset();
      reg_write(8'h14, 32'h0001_0033);      // masked edge, vec 0x33
      @(negedge clk); irq_in[2] = 1'b1;
      repeat (3) @(negedge clk);
      reg_write(8'h14, 32'h0000_0033);      // unmask
      count_msgs(5, c);
      chk("R7 masked edge dropped", c, 0);
      @(negedge clk); irq_in[2] = 1'b0;
      @(negedge clk); irq_in[2] = 1'b1;
      count_msgs(4, c);
      chk("R6 fresh edge after unmask", c, 1);

      // ---- level and end-of-interrupt (R8 R9)
      do_reset();
      reg_write(8'h16, 32'h0000_8055);      // level, high, vec 0x55
      @(negedge clk); irq_in[3] = 1'b1;
      @(negedge clk);
      chk("R8 first message", {31'd0, msg_valid}, 32'd1);
      chk("R8 vector", {24'd0, msg_vector}, 32'h55);
      count_msgs(5, c);
      chk("R8 locked while pending", c, 0);
      reg_read(8'h16, rd);
      chk("R8 remote-pending bit14", rd, 32'h0000_C055);
      bus_wr(7'h40, 32'h56);
      count_msgs(4, c);
      chk("R9 non-matching eoi no message", c, 0);
      reg_read(8'h16, rd);
      chk("R9 non-matching keeps pending", rd, 32'h0000_C055);
      bus_wr(7'h40, 32'h55);
      count_msgs(3, c);
      chk("R9 matching eoi redelivers", c, 1);
      @(negedge clk); irq_in[3] = 1'b0;
      bus_wr(7'h40, 32'h55);
      count_msgs(4, c);
      chk("R9 eoi with idle input silent", c, 0);
      reg_read(8'h16, rd);
      chk("R9 pending cleared", rd, 32'h0000_8055);

      // ---- shared vector, ordering (R9 R11)
      do_reset();
      reg_write(8'h17, 32'h0300_0000);
      reg_write(8'h19, 32'h0400_0000);
      reg_write(8'h16, 32'h0000_8055);
      reg_write(8'h18, 32'h0000_8055);
      @(negedge clk); irq_in[3] = 1'b1; irq_in[4] = 1'b1;
      @(negedge clk);
      chk("R11 lower pin first", {16'd0, msg_dest}, 32'h0300);
      @(negedge clk);
      chk("R11 next pin follows", {16'd0, msg_dest}, 32'h0400);
      chk("R11 second valid", {31'd0, msg_valid}, 32'd1);
      @(negedge clk);
      chk("R11 then idle", {31'd0, msg_valid}, 32'd0);
      irq_in[3] = 1'b0; irq_in[4] = 1'b0;
      bus_wr(7'h40, 32'h55);
      reg_read(8'h16, rd); chk("R9 shared clear pin3", rd, 32'h0000_8055);
      reg_read(8'h18, rd); chk("R9 shared clear pin4", rd, 32'h0000_8055);

      // ---- polarity (R12)
      do_reset();
      irq_in[0] = 1'b1;
      reg_write(8'h10, 32'h0000_A020);      // level, active low, vec 0x20
      count_msgs(4, c);
      chk("R12 high level idle", c, 0);
      @(negedge clk); irq_in[0] = 1'b0;
      @(negedge clk);
      chk("R12 low level delivers", {31'd0, msg_valid}, 32'd1);
      chk("R12 vector", {24'd0, msg_vector}, 32'h20);

      // ---- backpressure and arbitration (R10 R11)
      do_reset();
      reg_write(8'h12, 32'h0000_0061);
      reg_write(8'h14, 32'h0000_0062);
      @(negedge clk); msg_ready = 1'b0; irq_in[1] = 1'b1; irq_in[2] = 1'b1;
      @(negedge clk);
      chk("R11 lowest wins", {24'd0, msg_vector}, 32'h61);
      repeat (3) @(negedge clk);
      chk("R10 held valid", {31'd0, msg_valid}, 32'd1);
      chk("R10 held vector", {24'd0, msg_vector}, 32'h61);
      msg_ready = 1'b1;
      @(negedge clk);
      chk("R10 next after accept", {24'd0, msg_vector}, 32'h62);
      @(negedge clk);
      chk("R10 drained", {31'd0, msg_valid}, 32'd0);

      summary();
      $finish;
   end

endmodule